// File: doc/BRIEF.md
# Protected Processor Mode Control Register

This block is an 8-bit control register that sits on a simple CPU register bus at one fixed address. It sets how the processor's memory decoder and watchdog behave. The settings are a data-block enable, a pin-function select for four upper port pins, a watchdog action select, an internal-area expansion bit, a wait-state request for internal memory, and three reserved bits. A bus write changes the register only when a separate protect-enable input grants write access. Some bits also follow their own write rules.

The watchdog action bit can only be set by software. Once it is 1, only a system reset returns it to 0. While the flash rewrite-mode input is high, hardware holds the data-block enable and the expansion bit at 1. These two bits stay at 1 after rewrite mode ends, until software writes them again. The block drives each control bit out as its own signal. It also returns the whole byte on a read at its address.

Top module: `mode_ctrl_reg`

## Requirements
- R1: After reset the register value is 8'h08: bit 3 is 1 and all other bits are 0.
- R2: A write while `protectEn` is 0 has no effect. A write to any address other than `REG_ADDR` also has no effect.
- R3: An accepted write (`wrEn`=1, `addr`=`REG_ADDR`, `protectEn`=1) loads bit 0 (data block enable), bit 1 (port function select), bit 3 (area expansion) and bit 7 (wait state) from `wdata`. The new value is visible one clock later.
- R4: Bit 2 (watchdog action, 1 = reset, 0 = interrupt) is set by an accepted write with `wdata[2]`=1. Writing 0 to it has no effect. Only reset clears it.
- R5: Bits 6 to 4 always read 0, whatever value is written to them.
- R6: While `rewriteMode` is 1, bits 0 and 3 read 1 in the same cycle. Writes of 0 to these bits do not clear them.
- R7: After `rewriteMode` falls, bits 0 and 3 stay at 1 until an accepted write changes them.
- R8: `rdata` returns the register value when `addr` equals `REG_ADDR`, and 0 for any other address.
- R9: The outputs `dataBlockEn`, `portFuncSel`, `wdtResetSel`, `areaExpand` and `waitStateEn` equal bits 0, 1, 2, 3 and 7 of the register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Write data |
| protectEn | input | 1 | Write-access grant from the protect logic |
| rewriteMode | input | 1 | Flash rewrite mode is active |
| rdata | output | 8 | Read data for the current address |
| dataBlockEn | output | 1 | Data block enable (bit 0) |
| portFuncSel | output | 1 | 1 = port function, 0 = address output (bit 1) |
| wdtResetSel | output | 1 | 1 = watchdog reset, 0 = watchdog interrupt (bit 2) |
| areaExpand | output | 1 | Internal reserved-area expansion (bit 3) |
| waitStateEn | output | 1 | One wait state on internal memory (bit 7) |

## Verification
Random writes are mixed across the protect grant, address hit or miss, and rewrite mode, with random data. This separates gating by protect from gating by address, and shows whether forcing wins over a write of 0 in the same cycle. Directed cases cover two more points. Writing all ones shows that the reserved bits stay clear. Writing 0 to a set watchdog bit, and then resetting, shows that the bit is set-only and that reset clears it. A deasserted rewrite mode is then followed by reads, to show that the forced bits keep their 1 until a new write clears them.

// File: rtl/mode_ctrl_pkg.sv
package mode_ctrl_pkg;
  localparam int REG_W = 8;
  localparam int BIT_DBLK = 0;
  localparam int BIT_PORT = 1;
  localparam int BIT_WDT = 2;
  localparam int BIT_EXP = 3;
  localparam int BIT_WAIT = 7;
  localparam logic [REG_W-1:0] RESET_VAL = 8'h08;
  localparam logic [REG_W-1:0] FORCE_MASK = 8'h09;
  localparam logic [REG_W-1:0] RSVD_MASK = 8'h70;

  typedef struct packed {
    logic wrAccept;
    logic forceSet;
    logic rdHit;
  } strobe_t;
endpackage

// File: rtl/mode_ctrl_ctl.sv
module mode_ctrl_ctl
  import mode_ctrl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h005
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              protectEn,
  input  logic              rewriteMode,
  output strobe_t           strobes
);
  logic addrHit;

  always_comb begin
    addrHit          = (addr == REG_ADDR);
    strobes.rdHit    = addrHit;
    strobes.wrAccept = wrEn && addrHit && protectEn;
    strobes.forceSet = rewriteMode;
  end
endmodule

// File: rtl/mode_ctrl_dp.sv
module mode_ctrl_dp
  import mode_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] regVal,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] storedQ;
  logic [REG_W-1:0] storedD;
  logic [REG_W-1:0] forceMask;

  always_comb begin
    storedD = storedQ;
    if (strobes.wrAccept) begin
      storedD[BIT_DBLK] = wdata[BIT_DBLK];
      storedD[BIT_PORT] = wdata[BIT_PORT];
      storedD[BIT_WDT]  = storedQ[BIT_WDT] | wdata[BIT_WDT];
      storedD[BIT_EXP]  = wdata[BIT_EXP];
      storedD[BIT_WAIT] = wdata[BIT_WAIT];
    end
    if (strobes.forceSet) storedD = storedD | FORCE_MASK;
    storedD = storedD & ~RSVD_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) storedQ <= RESET_VAL;
    else       storedQ <= storedD;
  end

  always_comb begin
    forceMask = strobes.forceSet ? FORCE_MASK : '0;
    regVal    = storedQ | forceMask;
    rdata     = strobes.rdHit ? regVal : '0;
  end

  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regVal & RSVD_MASK) == '0);

  assert_wdt_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(regVal[BIT_WDT]) |-> regVal[BIT_WDT]);

  assert_force_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceSet |-> (regVal[BIT_DBLK] && regVal[BIT_EXP]));

  assert_no_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrAccept && !strobes.forceSet |=> $stable(storedQ));

  assert_write_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrAccept && !strobes.forceSet |=>
      storedQ[BIT_WAIT] == $past(wdata[BIT_WAIT]) &&
      storedQ[BIT_PORT] == $past(wdata[BIT_PORT]) &&
      storedQ[BIT_DBLK] == $past(wdata[BIT_DBLK]));
endmodule

// File: rtl/mode_ctrl_reg.sv
module mode_ctrl_reg
  import mode_ctrl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h005
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              protectEn,
  input  logic              rewriteMode,
  output logic [7:0]        rdata,
  output logic              dataBlockEn,
  output logic              portFuncSel,
  output logic              wdtResetSel,
  output logic              areaExpand,
  output logic              waitStateEn
);
  strobe_t          strobes;
  logic [REG_W-1:0] regVal;

  mode_ctrl_ctl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctl (
    .wrEn(wrEn), .addr(addr), .protectEn(protectEn),
    .rewriteMode(rewriteMode), .strobes(strobes)
  );

  mode_ctrl_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wdata(wdata),
    .regVal(regVal), .rdata(rdata)
  );

  always_comb begin
    dataBlockEn = regVal[BIT_DBLK];
    portFuncSel = regVal[BIT_PORT];
    wdtResetSel = regVal[BIT_WDT];
    areaExpand  = regVal[BIT_EXP];
    waitStateEn = regVal[BIT_WAIT];
  end
endmodule

// File: tb/mode_ctrl_reg_tb.sv
module mode_ctrl_reg_tb;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] REG_ADDR = 10'h005;

  logic clk = 0;
  logic rstN = 0;
  logic wrEn = 0;
  logic [ADDR_W-1:0] addr = REG_ADDR;
  logic [7:0] wdata = 0;
  logic protectEn = 0;
  logic rewriteMode = 0;
  logic [7:0] rdata;
  logic dataBlockEn, portFuncSel, wdtResetSel, areaExpand, waitStateEn;

  int checks = 0;
  int fails = 0;
  logic [7:0] model;

  always #5 clk = ~clk;

  mode_ctrl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .protectEn(protectEn), .rewriteMode(rewriteMode), .rdata(rdata),
    .dataBlockEn(dataBlockEn), .portFuncSel(portFuncSel),
    .wdtResetSel(wdtResetSel), .areaExpand(areaExpand),
    .waitStateEn(waitStateEn)
  );

  function automatic logic [7:0] nextVal(input logic [7:0] s, input logic wr,
      input logic hit, input logic prot, input logic rew, input logic [7:0] d);
    logic [7:0] n;
    n = s;
    if (wr && hit && prot) begin
      n[0] = d[0]; n[1] = d[1]; n[2] = s[2] | d[2]; n[3] = d[3];
      n[6:4] = 3'b000; n[7] = d[7];
    end
    if (rew) n = n | 8'h09;
    return n;
  endfunction

  function automatic logic [7:0] seen(input logic [7:0] s, input logic rew);
    return rew ? (s | 8'h09) : s;
  endfunction

  task automatic doCycle(input logic wr, input logic [ADDR_W-1:0] a,
      input logic [7:0] d, input logic prot, input logic rew);
    wrEn = wr; addr = a; wdata = d; protectEn = prot; rewriteMode = rew;
    @(posedge clk);
    model = nextVal(model, wr, a == REG_ADDR, prot, rew, d);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic checkAll(input string tag);
    logic [7:0] expV, expR, gotBits, expBits;
    expV = seen(model, rewriteMode);
    expR = (addr == REG_ADDR) ? expV : 8'h00;
    expBits = {expV[7], expV[3], expV[2], expV[1], expV[0]};
    gotBits = {3'b000, waitStateEn, areaExpand, wdtResetSel, portFuncSel, dataBlockEn};
    checks++;
    if (rdata !== expR || gotBits[4:0] !== expBits[4:0]) begin
      fails++;
      $display("FAIL %s: rdata=%h bits=%b expected rdata=%h bits=%b",
               tag, rdata, gotBits[4:0], expR, expBits[4:0]);
    end
  endtask

  task automatic doReset();
    rstN = 0;
    @(posedge clk);
    model = 8'h08;
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'd1234);
    model = 8'h08;
    @(negedge clk);
    doReset();
    checkAll("R1 reset value");
    doCycle(1, REG_ADDR, 8'hFF, 0, 0);
    checkAll("R2 write without protect");
    doCycle(1, REG_ADDR + 1, 8'hFF, 1, 0);
    checkAll("R2 write to other address");
    addr = REG_ADDR + 1; #1;
    checkAll("R8 read at other address gives 0");
    doCycle(1, REG_ADDR, 8'h83, 1, 0);
    checkAll("R3 R9 accepted write of 83");
    doCycle(1, REG_ADDR, 8'hFF, 1, 0);
    checkAll("R5 reserved bits read 0 after FF");
    doCycle(1, REG_ADDR, 8'h00, 1, 0);
    checkAll("R4 write 0 keeps watchdog bit");
    doReset();
    checkAll("R4 reset clears watchdog bit");
    doCycle(1, REG_ADDR, 8'h00, 1, 1);
    checkAll("R6 force wins over write of 0");
    doCycle(0, REG_ADDR, 8'h00, 0, 0);
    checkAll("R7 forced bits stay after rewrite ends");
    doCycle(1, REG_ADDR, 8'h00, 1, 0);
    checkAll("R7 software clears forced bits");
    rewriteMode = 1; #1;
    checkAll("R6 force visible in same cycle");
    rewriteMode = 0;

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      doCycle(r[0], (r[3:1] != 0) ? REG_ADDR : ADDR_W'(r[13:4]), r[21:14],
              r[22] | r[23], (r[27:24] == 0));
      checkAll("R3 R4 R5 R6 R8 random");
      if (i % 97 == 96) begin
        doReset();
        checkAll("R1 random reset");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule